// File: doc/BRIEF.md
# Cross-Domain Counter Snapshot Reader

This block lets a host on a fast bus clock read a 32-bit free-running counter that lives in a slow, unrelated counter clock. The bus domain never samples the live count, because a direct read could catch bits mid-transition and return a metastable or torn word. The host asks for a snapshot instead. It writes 1 to a request bit, and a toggle carries that request across to the counter domain through a two-flop synchronizer. On the synchronized toggle edge, the counter domain loads the current count into a capture register and flips an acknowledge toggle. That toggle returns through its own two-flop synchronizer. When the bus side sees the acknowledge edge, it copies the capture register into its holding register in one step, so all 32 bits come from the same capture.

The bus side is a two-state machine. In `S_IDLE`, the held value is fresh and `snap_ready_o` is 1. Transition `T_START` is a write with the request bit at 1: it flips the request toggle and moves to `S_PEND`, where `snap_ready_o` is 0. Transition `T_DONE` is the returning acknowledge edge: it loads the holding register and moves back to `S_IDLE`. Software writes the request and then polls the status bit until the value is valid. The counter can start from a preset value, which lets the modulo-2^32 wrap be reached in a short run.

Top module: `snap_cdc_reader`

## Requirements
- R1: After bus reset, `snap_value_o` is 0 and `snap_ready_o` is 1.
- R2: A write with `snap_wdata_i`=1 while `snap_ready_o`=1 drops `snap_ready_o` to 0 on the next bus clock edge.
- R3: Every snapshot equals one whole counter value that the count held at or after the request edge and at or before the bus cycle in which `snap_ready_o` returns to 1.
- R4: `snap_value_o` changes only on the bus edge that ends a pending request; between requests and while one is pending, it holds its previous value.
- R5: `snap_ready_o` returns to 1 within 60 bus cycles of the request when the counter clock is 13 times slower than the bus clock.
- R6: A write during a pending request is ignored: it starts no second capture, and once the first snapshot is ready, the value and the status stay unchanged.
- R7: A write with `snap_wdata_i`=0 starts no capture and leaves both the value and the status unchanged.
- R8: The counter increments by 1 on every counter clock edge out of reset, starting from parameter `CNT_INIT`, and wraps modulo 2^32.
- R9: Successive snapshots never decrease when compared modulo 2^32, meaning the forward distance from the previous snapshot is below 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| snap_wr_i | input | 1 | Write strobe to the snapshot request bit |
| snap_wdata_i | input | 1 | Request bit value; 1 requests a capture |
| snap_value_o | output | 32 | Held snapshot of the counter |
| snap_ready_o | output | 1 | 1 = held value fresh, 0 = capture pending |
| cnt_clk | input | 1 | Slow counter clock |
| cnt_rst_n | input | 1 | Counter-domain reset, active low |

## Verification
The bench keeps its own model of the count. It checks that each snapshot falls inside the window between the request and the ready status, taking the wrap into account. A design that sampled the live counter without the handshake, or that loaded the holding register before the acknowledge arrived, would return stale or out-of-window words. The bench also writes a second time into a pending capture, where a design without the busy gate would lose the toggle parity and either hang with ready at 0 or change the value later. It writes a zero to the request bit, which must start nothing. It starts the counter near the top of its range so that snapshots straddle the wrap, where a design that compared values with signed arithmetic or used a narrowed capture path would break.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int unsigned CNT_W = 32;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_PEND = 1'b1
    } bus_state_t;
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic tgl_o,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], tgl_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign tgl_o  = chain_q[STAGES-1];
    assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cnt_capture.sv
module cnt_capture
    import snap_pkg::*;
#(
    parameter int unsigned            SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0]       CNT_INIT    = '0
) (
    input  logic             cnt_clk,
    input  logic             cnt_rst_n,
    input  logic             req_tgl_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             ack_tgl_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             ack_tgl_q;
    logic             req_edge;
    logic             req_level;

    toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk    (cnt_clk),
        .rst_n  (cnt_rst_n),
        .tgl_i  (req_tgl_i),
        .tgl_o  (req_level),
        .edge_o (req_edge)
    );

    always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
        if (!cnt_rst_n) begin
            cnt_q <= CNT_INIT;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
        if (!cnt_rst_n) begin
            cap_q     <= '0;
            ack_tgl_q <= 1'b0;
        end else if (req_edge) begin
            cap_q     <= cnt_q;
            ack_tgl_q <= req_level;
        end
    end

    assign cap_o     = cap_q;
    assign ack_tgl_o = ack_tgl_q;

    // R8: free-running count, modulo 2^32
    p_count_step_r8: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 32'd1);

    // R3: capture register moves only on a synchronized request edge
    p_cap_only_on_req_r3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        !req_edge |=> $stable(cap_q));

    // R3: capture holds the count seen on the request edge, and the acknowledge flips
    p_cap_ack_r3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        req_edge |=> (cap_q == $past(cnt_q)) && (ack_tgl_q != $past(ack_tgl_q)));
endmodule

// File: rtl/bus_snap_ctrl.sv
module bus_snap_ctrl
    import snap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             wr_i,
    input  logic             wdata_i,
    input  logic [CNT_W-1:0] cap_i,
    input  logic             ack_tgl_i,
    output logic             req_tgl_o,
    output logic [CNT_W-1:0] value_o,
    output logic             ready_o
);
    bus_state_t       state_q, state_d;
    logic             req_tgl_q;
    logic [CNT_W-1:0] hold_q;
    logic             ack_edge;
    logic             ack_level;
    logic             t_start;
    logic             t_done;

    toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk    (bus_clk),
        .rst_n  (bus_rst_n),
        .tgl_i  (ack_tgl_i),
        .tgl_o  (ack_level),
        .edge_o (ack_edge)
    );

    // next state and transition strobes
    always_comb begin
        state_d = state_q;
        t_start = 1'b0;
        t_done  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_i && wdata_i) begin
                    t_start = 1'b1;
                    state_d = S_PEND;
                end
            end
            S_PEND: begin
                if (ack_edge) begin
                    t_done  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs of the machine
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            req_tgl_q <= 1'b0;
            hold_q    <= '0;
        end else begin
            if (t_start) begin
                req_tgl_q <= ~req_tgl_q;
            end
            if (t_done) begin
                hold_q <= cap_i;
            end
        end
    end

    assign req_tgl_o = req_tgl_q;
    assign value_o   = hold_q;
    assign ready_o   = (state_q == S_IDLE);

    // R2: request in idle flips the toggle and enters pending
    p_start_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (state_q == S_IDLE && wr_i && wdata_i) |=>
            (state_q == S_PEND) && (req_tgl_q != $past(req_tgl_q)));

    // R6: writes while pending leave the request toggle alone
    p_ignore_pending_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (state_q == S_PEND && wr_i) |=> $stable(req_tgl_q));

    // R7: zero written to the request bit does nothing
    p_zero_write_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (state_q == S_IDLE && wr_i && !wdata_i) |=> $stable(req_tgl_q) && (state_q == S_IDLE));

    // R4: holding register changes only on the returning acknowledge
    p_hold_stable_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !ack_edge |=> $stable(hold_q));

    // R4: once acknowledged, the returned toggle matches the request toggle
    p_ack_parity_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (state_q == S_PEND && ack_edge) |=> (ack_level == req_tgl_q) && (state_q == S_IDLE));
endmodule

// File: rtl/snap_cdc_reader.sv
module snap_cdc_reader
    import snap_pkg::*;
#(
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [31:0]      CNT_INIT    = 32'h0000_0000
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        snap_wr_i,
    input  logic        snap_wdata_i,
    output logic [31:0] snap_value_o,
    output logic        snap_ready_o,
    input  logic        cnt_clk,
    input  logic        cnt_rst_n
);
    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] cap_word;

    bus_snap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .wr_i      (snap_wr_i),
        .wdata_i   (snap_wdata_i),
        .cap_i     (cap_word),
        .ack_tgl_i (ack_tgl),
        .req_tgl_o (req_tgl),
        .value_o   (snap_value_o),
        .ready_o   (snap_ready_o)
    );

    cnt_capture #(.SYNC_STAGES(SYNC_STAGES), .CNT_INIT(CNT_INIT)) u_cnt (
        .cnt_clk   (cnt_clk),
        .cnt_rst_n (cnt_rst_n),
        .req_tgl_i (req_tgl),
        .cap_o     (cap_word),
        .ack_tgl_o (ack_tgl)
    );
endmodule

// File: tb/tb_snap_cdc_reader.sv
module tb_snap_cdc_reader;
    localparam logic [31:0] INIT    = 32'hFFFF_FF80;
    localparam int          NVEC    = 8;
    localparam int          LAT_MAX = 60;

    // stimulus table: gap (counter periods), double write, leading zero write
    localparam int GAP   [NVEC] = '{5, 17, 40, 3, 60, 11, 30, 25};
    localparam bit DBL   [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam bit ZFRST [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    logic        bus_clk = 1'b0;
    logic        cnt_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        cnt_rst_n = 1'b0;
    logic        snap_wr_i = 1'b0;
    logic        snap_wdata_i = 1'b0;
    logic [31:0] snap_value_o;
    logic        snap_ready_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_cnt;

    always #4 bus_clk = ~bus_clk;
    always #52 cnt_clk = ~cnt_clk;

    always @(posedge cnt_clk or negedge cnt_rst_n) begin
        if (!cnt_rst_n) model_cnt <= INIT;
        else            model_cnt <= model_cnt + 32'd1;
    end

    snap_cdc_reader #(.CNT_INIT(INIT)) dut (
        .bus_clk      (bus_clk),
        .bus_rst_n    (bus_rst_n),
        .snap_wr_i    (snap_wr_i),
        .snap_wdata_i (snap_wdata_i),
        .snap_value_o (snap_value_o),
        .snap_ready_o (snap_ready_o),
        .cnt_clk      (cnt_clk),
        .cnt_rst_n    (cnt_rst_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_bit(input logic d);
        @(negedge bus_clk);
        snap_wr_i    = 1'b1;
        snap_wdata_i = d;
        @(negedge bus_clk);
        snap_wr_i    = 1'b0;
        snap_wdata_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        logic [31:0] lo, hi, v;
        bit          wrapped;
        wrapped = 1'b0;
        repeat (3) @(negedge cnt_clk);
        cnt_rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);
        // R1: reset state
        check(snap_value_o == 32'd0, "R1 value", snap_value_o, 32'd0);
        check(snap_ready_o == 1'b1, "R1 ready", {31'd0, snap_ready_o}, 32'd1);
        bus_rst_n = 1'b1;
        @(negedge bus_clk);
        prev = 32'd0;

        for (int i = 0; i < NVEC; i++) begin
            repeat (GAP[i] * 13) @(negedge bus_clk);
            if (ZFRST[i]) begin
                write_bit(1'b0);
                repeat (60) @(negedge bus_clk);
                check(snap_ready_o == 1'b1 && snap_value_o == prev, "R7 zero write",
                      snap_value_o, prev);
            end
            // request
            snap_wr_i = 1'b1;
            snap_wdata_i = 1'b1;
            lo = model_cnt;
            @(negedge bus_clk);
            snap_wr_i = 1'b0;
            snap_wdata_i = 1'b0;
            check(snap_ready_o == 1'b0, "R2 ready drop", {31'd0, snap_ready_o}, 32'd0);
            check(snap_value_o == prev, "R4 hold while pending", snap_value_o, prev);
            begin
                int lat;
                lat = 1;
                if (DBL[i]) begin
                    repeat (4) @(negedge bus_clk);
                    lat += 4;
                    snap_wr_i = 1'b1;
                    snap_wdata_i = 1'b1;
                    @(negedge bus_clk);
                    lat += 1;
                    snap_wr_i = 1'b0;
                    snap_wdata_i = 1'b0;
                end
                while (!snap_ready_o && lat < 200) begin
                    @(negedge bus_clk);
                    lat++;
                end
                check(lat <= LAT_MAX, "R5 latency", lat, LAT_MAX);
            end
            hi = model_cnt;
            v  = snap_value_o;
            check((v - lo) <= (hi - lo), "R3 window", v, lo);
            if (i > 0) begin
                check((v - prev) < 32'h8000_0000, "R9 monotonic", v, prev);
                if (v < prev) wrapped = 1'b1;
            end
            if (DBL[i]) begin
                repeat (90) @(negedge bus_clk);
                check(snap_ready_o == 1'b1 && snap_value_o == v, "R6 second write ignored",
                      snap_value_o, v);
            end
            prev = v;
        end
        // R8: the count wrapped through zero between snapshots
        check(wrapped, "R8 wrap seen", {31'd0, wrapped}, 32'd1);

        // R1: reset reapplied mid-run
        @(negedge bus_clk);
        bus_rst_n = 1'b0;
        @(negedge bus_clk);
        check(snap_value_o == 32'd0 && snap_ready_o == 1'b1, "R1 re-reset",
              snap_value_o, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule